// File: doc/BRIEF.md
# Code Symbol to PSK Symbol Mapper

This block takes a serial stream of coded bits that has already been framed with sync markers and groups consecutive bits into modulation symbols. It supports offset QPSK, 8-ary PSK and 16-ary PSK. Symbols are always cut from the single serialized stream. No lane is kept per encoder. Grouping therefore runs on across codeword boundaries and is never realigned at the start of a codeword. A symbol whose bits come from two codewords is flagged so that a checker can follow the carry of leftover bits. In offset QPSK mode, two extra bit lanes show the staggered in-phase and quadrature levels. The quadrature lane changes one bit period after the in-phase lane.

Bits enter on a valid/ready port and symbols leave on a valid/ready port. A bit transfers on a rising edge when `bit_valid` and `bit_ready` are both high. A symbol transfers when `sym_valid` and `sym_ready` are both high. The block holds one finished symbol. It accepts bits that only extend the symbol being built even while the held symbol waits. It lowers `bit_ready` only when the offered bit would complete a new symbol and the held one has not yet left. The mode is a plain control input that may change only while reset is asserted.

Top module: `psk_symbol_mapper`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `sym_valid` is 0. While `rst` is high, `bit_ready` is 1 and both `lane_i` and `lane_q` are 0.
- R2: Mode 0 (offset QPSK) groups bits in pairs. The first bit of a pair lands in `sym_index[1]` and the second in `sym_index[0]`, with no Gray coding. Bits 3:2 are 0.
- R3: In mode 0, `lane_i` takes the value of the first bit of a pair and `lane_q` takes the value of the second bit. Each lane takes its new value on the edge where that bit is accepted. The two lanes never change on the same cycle, and a lane changes only after a bit was accepted.
- R4: Mode 1 (8PSK) groups 3 bits, with the first received bit as the most significant bit. It emits the Gray code b ^ (b >> 1) in `sym_index[2:0]` with `sym_index[3]` = 0.
- R5: Mode 2 (16PSK) groups 4 bits, with the first received bit as the most significant bit. It emits the 4-bit Gray code b ^ (b >> 1). Mode 3 behaves as mode 2.
- R6: `bit_cw_start` has no effect on the grouping phase. Symbol k always holds stream bits k*B to k*B+B-1, where B is the number of bits per symbol.
- R7: `sym_straddle` is 1 exactly for a symbol in which a bit marked `bit_cw_start` sits at any position other than the first.
- R8: While `sym_valid` is high and `sym_ready` is low, `sym_index` and `sym_straddle` hold. `bit_ready` is low only when such a symbol is held and the next bit would complete a symbol. No bit is lost or duplicated.
- R9: `sym_valid` rises on the edge that accepts the last bit of a symbol, and is visible in the cycle after.
- R10: `mode` is stable whenever `rst` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 offset QPSK, 1 8PSK, 2 16PSK, 3 as 2 |
| bit_valid | input | 1 | A coded bit is offered |
| bit_ready | output | 1 | The block can take the offered bit |
| bit_data | input | 1 | Coded bit value |
| bit_cw_start | input | 1 | Offered bit is the first bit of a framed codeword |
| sym_valid | output | 1 | A finished symbol is held |
| sym_ready | input | 1 | Downstream takes the held symbol |
| sym_index | output | 4 | Symbol index (MAX_BPS bits) |
| sym_straddle | output | 1 | Held symbol mixes bits from two codewords |
| lane_i | output | 1 | Offset QPSK in-phase level |
| lane_q | output | 1 | Offset QPSK quadrature level, one bit behind |

## Verification
Each mode is run with mixed bit patterns against a reference grouping computed in the bench. Codeword starts are placed both on and off symbol boundaries. This separates a correct carry of leftover bits from a mapper that realigns at each codeword. All-ones and all-zeros streams show Gray coding and bit order at the ends of the symbol range. The same streams are run with bursty `sym_ready` to show that back-pressure stalls only the completing bit and loses nothing. A directed test fills the symbol holder and confirms that `bit_ready` drops exactly on the completing bit.

// File: rtl/psk_map_pkg.sv
package psk_map_pkg;
  typedef enum logic [1:0] {
    PM_OQPSK = 2'd0,
    PM_8PSK  = 2'd1,
    PM_16PSK = 2'd2,
    PM_RSVD  = 2'd3
  } pm_mode_e;

  // Bits gathered per symbol for a mode.
  function automatic logic [2:0] pm_bits(input pm_mode_e m);
    case (m)
      PM_OQPSK: pm_bits = 3'd2;
      PM_8PSK:  pm_bits = 3'd3;
      default:  pm_bits = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/psk_bit_gatherer.sv
module psk_bit_gatherer #(
  parameter int MAX_BPS = 4,
  localparam int CNT_W = $clog2(MAX_BPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               bit_in,
  input  logic               cw_in,
  input  logic [CNT_W-1:0]   last_idx,
  output logic               at_last,
  output logic [MAX_BPS-1:0] word,
  output logic               straddle
);
  logic [CNT_W-1:0]   cnt;
  logic [MAX_BPS-2:0] acc;
  logic               strad_q;

  assign at_last  = (cnt == last_idx);
  // Earlier bits sit above the current one; acc is cleared per symbol,
  // so unused upper bits stay zero for narrower modes.
  assign word     = {acc, bit_in};
  assign straddle = strad_q | (cw_in && (cnt != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      acc     <= '0;
      strad_q <= 1'b0;
    end else if (take) begin
      if (at_last) begin
        cnt     <= '0;
        acc     <= '0;
        strad_q <= 1'b0;
      end else begin
        cnt     <= cnt + 1'b1;
        acc     <= {acc[MAX_BPS-3:0], bit_in};
        strad_q <= straddle;
      end
    end
  end
endmodule

// File: rtl/psk_gray_coder.sv
module psk_gray_coder #(
  parameter int W = 4
) (
  input  logic         bypass,
  input  logic [W-1:0] bin,
  output logic [W-1:0] code
);
  logic [W-1:0] gray;
  for (genvar g = 0; g < W; g++) begin : g_bit
    if (g == W - 1) begin : g_top
      assign gray[g] = bin[g];
    end else begin : g_low
      assign gray[g] = bin[g] ^ bin[g+1];
    end
  end
  assign code = bypass ? bin : gray;
endmodule

// File: rtl/psk_oqpsk_lanes.sv
module psk_oqpsk_lanes (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic first,
  input  logic bit_in,
  output logic lane_i,
  output logic lane_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lane_i <= 1'b0;
      lane_q <= 1'b0;
    end else if (en) begin
      if (first) lane_i <= bit_in;
      else       lane_q <= bit_in;
    end
  end
endmodule

// File: rtl/psk_symbol_mapper.sv
module psk_symbol_mapper
  import psk_map_pkg::*;
#(
  parameter int MAX_BPS = 4,
  localparam int CNT_W = $clog2(MAX_BPS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mode,
  input  logic               bit_valid,
  output logic               bit_ready,
  input  logic               bit_data,
  input  logic               bit_cw_start,
  output logic               sym_valid,
  input  logic               sym_ready,
  output logic [MAX_BPS-1:0] sym_index,
  output logic               sym_straddle,
  output logic               lane_i,
  output logic               lane_q
);
  pm_mode_e           mode_e;
  logic [CNT_W-1:0]   last_idx;
  logic               at_last;
  logic               take;
  logic               complete;
  logic [MAX_BPS-1:0] word;
  logic [MAX_BPS-1:0] coded;
  logic               straddle;
  logic               is_oq;

  assign mode_e   = pm_mode_e'(mode);
  assign is_oq    = (mode_e == PM_OQPSK);
  assign last_idx = CNT_W'(pm_bits(mode_e) - 3'd1);

  // Only a completing bit needs room in the symbol holder.
  assign bit_ready = !sym_valid || sym_ready || !at_last;
  assign take      = bit_valid && bit_ready;
  assign complete  = take && at_last;

  psk_bit_gatherer #(.MAX_BPS(MAX_BPS)) u_gather (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .bit_in   (bit_data),
    .cw_in    (bit_cw_start),
    .last_idx (last_idx),
    .at_last  (at_last),
    .word     (word),
    .straddle (straddle)
  );

  psk_gray_coder #(.W(MAX_BPS)) u_gray (
    .bypass (is_oq),
    .bin    (word),
    .code   (coded)
  );

  psk_oqpsk_lanes u_lanes (
    .clk    (clk),
    .rst    (rst),
    .en     (take && is_oq),
    .first  (!at_last),
    .bit_in (bit_data),
    .lane_i (lane_i),
    .lane_q (lane_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_valid    <= 1'b0;
      sym_index    <= '0;
      sym_straddle <= 1'b0;
    end else if (complete) begin
      sym_valid    <= 1'b1;
      sym_index    <= coded;
      sym_straddle <= straddle;
    end else if (sym_ready) begin
      sym_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/psk_symbol_mapper_chk.sv
module psk_symbol_mapper_chk #(
  parameter int MAX_BPS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         mode,
  input logic               bit_valid,
  input logic               bit_ready,
  input logic               sym_valid,
  input logic               sym_ready,
  input logic [MAX_BPS-1:0] sym_index,
  input logic               sym_straddle,
  input logic               lane_i,
  input logic               lane_q
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sym_valid);

  a_r8_hold_symbol: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && !sym_ready) |=> (sym_valid && $stable(sym_index) && $stable(sym_straddle)));

  a_r8_stall_cause: assert property (@(posedge clk) disable iff (rst)
    !bit_ready |-> (sym_valid && !sym_ready));

  a_r3_lanes_apart: assert property (@(posedge clk) disable iff (rst)
    !($changed(lane_i) && $changed(lane_q)));

  a_r3_lane_after_accept: assert property (@(posedge clk) disable iff (rst)
    ($changed(lane_i) || $changed(lane_q)) |-> $past(bit_valid && bit_ready));

  a_r2_oq_range: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && mode == 2'd0) |-> (sym_index[MAX_BPS-1:2] == '0));

  a_r4_8psk_range: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && mode == 2'd1) |-> (sym_index[MAX_BPS-1] == 1'b0));

  a_r10_mode_fixed: assert property (@(posedge clk) disable iff (rst)
    $stable(mode));
endmodule

bind psk_symbol_mapper psk_symbol_mapper_chk #(.MAX_BPS(MAX_BPS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .mode         (mode),
  .bit_valid    (bit_valid),
  .bit_ready    (bit_ready),
  .sym_valid    (sym_valid),
  .sym_ready    (sym_ready),
  .sym_index    (sym_index),
  .sym_straddle (sym_straddle),
  .lane_i       (lane_i),
  .lane_q       (lane_q)
);

// File: tb/psk_symbol_mapper_bench.sv
module psk_symbol_mapper_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       bit_valid = 1'b0;
  logic       bit_ready;
  logic       bit_data = 1'b0;
  logic       bit_cw_start = 1'b0;
  logic       sym_valid;
  logic       sym_ready = 1'b1;
  logic [3:0] sym_index;
  logic       sym_straddle;
  logic       lane_i;
  logic       lane_q;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  psk_symbol_mapper u_psk_symbol_mapper (
    .clk(clk), .rst(rst), .mode(mode),
    .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .bit_cw_start(bit_cw_start),
    .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_index(sym_index), .sym_straddle(sym_straddle),
    .lane_i(lane_i), .lane_q(lane_q)
  );

  typedef struct packed {
    logic [1:0]  md;
    logic [23:0] bits;   // bit k of the stream is bits[k]
    logic [23:0] cw;
    logic        stall;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 24'hA5C396, 24'h000101, 1'b0},  // R2 R3, starts on even bits
    '{2'd1, 24'h3C5A71, 24'h010101, 1'b0},  // R4 R6 R7, starts at offsets 0,2,1
    '{2'd2, 24'h9E1B47, 24'h000041, 1'b1},  // R5 R7, start at offset 2
    '{2'd1, 24'hFFFFFF, 24'h000001, 1'b1},  // R4 all ones
    '{2'd0, 24'h6D2E81, 24'h000009, 1'b1},  // R2 R7, start on odd bit
    '{2'd2, 24'h000000, 24'h001001, 1'b0},  // R5 R6 aligned starts
    '{2'd3, 24'hF0C35A, 24'h000101, 1'b1}   // R5 mode 3 as 16PSK
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1'b1; mode = m; bit_valid = 1'b0; sym_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int bps_of(input logic [1:0] m);
    return (m == 2'd0) ? 2 : (m == 2'd1) ? 3 : 4;
  endfunction

  task automatic run_vec(input vec_t v);
    int bps = bps_of(v.md);
    int nsym = 24 / bps;
    int fed = 0, got = 0, cyc = 0;
    bit prev_took = 0;
    logic prev_bit = 0;
    int prev_pos = 0;
    logic ei = 0, eq = 0;
    do_reset(v.md);
    while (got < nsym && cyc < 400) begin
      @(negedge clk);
      if (v.md == 2'd0 && prev_took) begin
        if (prev_pos % 2 == 0) ei = prev_bit; else eq = prev_bit;
        chk(lane_i == ei, "R3 lane_i", lane_i, ei);
        chk(lane_q == eq, "R3 lane_q", lane_q, eq);
      end
      sym_ready    = v.stall ? (cyc % 3 != 1) : 1'b1;
      bit_valid    = (fed < 24);
      bit_data     = (fed < 24) ? v.bits[fed] : 1'b0;
      bit_cw_start = (fed < 24) ? v.cw[fed] : 1'b0;
      #1;
      if (sym_valid && sym_ready) begin
        int b = 0;
        bit s = 0;
        int e;
        for (int p = 0; p < bps; p++) begin
          b = (b << 1) | int'(v.bits[got*bps+p]);
          if (v.cw[got*bps+p] && p != 0) s = 1;
        end
        e = (v.md == 2'd0) ? b : (b ^ (b >> 1));
        chk(int'(sym_index) == e, "R2/R4/R5/R6 sym_index", sym_index, e);
        chk(sym_straddle == s, "R7 sym_straddle", sym_straddle, s);
        got++;
      end
      prev_took = bit_valid && bit_ready;
      prev_bit  = bit_data;
      prev_pos  = fed;
      if (prev_took) fed++;
      cyc++;
    end
    chk(got == nsym, "R8 symbol count", got, nsym);
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    rst = 1'b1; mode = 2'd2;
    repeat (3) @(negedge clk);
    chk(sym_valid == 1'b0, "R1 sym_valid", sym_valid, 0);
    chk(bit_ready == 1'b1, "R1 bit_ready", bit_ready, 1);
    chk(lane_i == 1'b0 && lane_q == 1'b0, "R1 lanes", {lane_i, lane_q}, 0);

    for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

    // R8 R9: 16PSK, downstream blocked, bits 1 0 1 1 then 0 1 1 0
    do_reset(2'd2);
    sym_ready = 1'b0;
    for (int k = 0; k < 4; k++) begin
      bit_valid = 1'b1; bit_data = (k != 1); bit_cw_start = 1'b0;
      #1;
      chk(sym_valid == 1'b0, "R9 no early valid", sym_valid, 0);
      @(negedge clk);
    end
    chk(sym_valid == 1'b1, "R9 valid after last bit", sym_valid, 1);
    chk(sym_index == 4'b1110, "R5 gray of 1011", sym_index, 4'b1110);
    for (int k = 0; k < 3; k++) begin
      bit_data = (k != 0);
      #1;
      chk(bit_ready == 1'b1, "R8 partial bits accepted", bit_ready, 1);
      @(negedge clk);
    end
    bit_data = 1'b0;
    #1;
    chk(bit_ready == 1'b0, "R8 completing bit stalls", bit_ready, 0);
    repeat (2) @(negedge clk);
    chk(sym_index == 4'b1110, "R8 held index", sym_index, 4'b1110);
    sym_ready = 1'b1;
    #1;
    chk(bit_ready == 1'b1, "R8 ready on release", bit_ready, 1);
    @(negedge clk);
    bit_valid = 1'b0;
    chk(sym_valid == 1'b1, "R8 next symbol", sym_valid, 1);
    chk(sym_index == 4'b0101, "R8 gray of 0110", sym_index, 4'b0101);
    @(negedge clk);
    chk(sym_valid == 1'b0, "R8 drained", sym_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule